// File: doc/BRIEF.md
# CAN bit timing synchronizer

This block cuts each nominal bit on a CAN-style bus into time quanta. The quantum ticks come from an external enable. Each bit is split into four segments, in this order: a one-quantum sync segment, a propagation segment, a first phase segment and a second phase segment. The sample strobe fires on the tick that closes the first phase segment, and the block latches the bus level on that tick. The bit-boundary strobe fires on the tick that closes the second phase segment.

The block also keeps its local bit clock lined up with the transmitter. A falling edge (recessive 1 to dominant 0) while the frame logic reports an idle bus restarts the bit at once. This is hard synchronization. During a frame, an edge away from the expected sync tick moves the timing instead. A late edge stretches the first phase segment. An early edge trims the second phase segment. Each correction is capped by a programmable jump width, and the second phase segment never ends sooner than two quanta after the sample point.

A frame decoder or transmitter sits next to this block. It feeds in quantum ticks from a prescaler, drives the idle flag, and uses the two strobes to move bits in and out.

Top module: `cbt_bit_timer`

## Requirements
- R1: After reset the block is idle. `bit_o` is 1 and neither strobe fires until a hard synchronization takes place.
- R2: The bus is observed only on ticks (cycles with `tq_en_i` high). An edge tick is a tick that sees `bus_i`=0 when the previous tick saw 1. A hard synchronization needs an edge tick with `bus_idle_i`=1. An edge tick while idle with `bus_idle_i`=0 is ignored and produces no strobe.
- R3: A hard synchronization on tick 0 starts the sync quantum there. The sample strobe then fires on tick 1+PROP+PH1 and the boundary strobe on tick 1+PROP+PH1+PH2. Later bits repeat with period 1+PROP+PH1+PH2 ticks.
- R4: Both strobes are one clock wide and occur only on tick cycles. From the cycle after a sample strobe, `bit_o` holds the `bus_i` level seen on that strobe.
- R5: Phase error is counted in ticks from the tick that opened the current sync quantum. Take an edge tick during a frame (`bus_idle_i`=0) that lies d ticks later, with 1 ≤ d ≤ PROP+PH1. It lengthens the first phase segment by min(d, SJW), and the sample and boundary strobes of that bit move later by the same amount.
- R6: Take an edge tick that falls e ticks before the expected next sync tick, counted from the sample tick onward. It shortens the second phase segment by min(e, SJW). When the full e is applied, the boundary strobe fires on that edge tick and the next bit's sync quantum starts there.
- R7: An edge tick that coincides with the tick opening a sync quantum causes no correction.
- R8: At most one synchronization, hard or soft, is made per bit. Further edge ticks in the same bit are ignored.
- R9: A programmed length of 0 for PROP or PH1 acts as 1. A PH2 below 2 acts as 2. An SJW above the effective PH2 acts as the effective PH2.
- R10: An edge tick with `bus_idle_i`=1 in a running bit that has not yet synchronized restarts the bit on that tick. No strobe fires on that tick.
- R11: At least two ticks separate a sample strobe from the next boundary strobe, even when an early edge would trim more. Sample and boundary never fire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tq_en_i | input | 1 | Time-quantum tick enable |
| bus_i | input | 1 | Bus level, 0 dominant, 1 recessive |
| bus_idle_i | input | 1 | High while waiting for a start bit; arms hard synchronization |
| prop_seg_i | input | SEG_W | Propagation segment length in quanta |
| ph1_seg_i | input | SEG_W | First phase segment length in quanta |
| ph2_seg_i | input | SEG_W | Second phase segment length in quanta |
| sjw_i | input | SEG_W | Resynchronization jump width in quanta |
| sample_o | output | 1 | One-cycle strobe at the sample point |
| bit_o | output | 1 | Bus level captured at the last sample point |
| bound_o | output | 1 | One-cycle strobe at the end of the bit |

## Verification
The tests place single falling edges at chosen tick offsets. One sits on the sync tick, which separates a correct no-op from a wrong correction. Two sit one and four ticks late, which shows a correction below the jump width apart from a capped one. Two sit one and two ticks before the next sync, which separates a full early correction that ends the bit on the spot from one held back by the processing-time floor. Other patterns cover a second edge in an already corrected bit, a start edge while the idle flag is low and later high, a mid-bit hard restart, and an out-of-range configuration whose clamped jump width gives a different sample tick than the raw value would.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    // Fixed processing time after the sample point, in quanta
    localparam int unsigned IPT_TQ = 2;

    // Segment currently being counted
    typedef enum logic [2:0] {
        SEG_IDLE = 3'd0,
        SEG_SYNC = 3'd1,
        SEG_PROP = 3'd2,
        SEG_PH1  = 3'd3,
        SEG_PH2  = 3'd4
    } seg_e;

    // Synchronization decision taken on one tick
    typedef struct packed {
        logic hard;     // restart bit from this tick
        logic late;     // stretch first phase segment
        logic early;    // trim second phase segment
        logic end_now;  // early trim closes the bit on this tick
    } sync_act_t;

endpackage

// File: rtl/cbt_edge_det.sv
module cbt_edge_det (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tq_en_i,
    input  logic bus_i,
    output logic fall_o
);

    // Bus level seen on the previous tick; recessive out of reset
    logic prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q <= 1'b1;
        end else if (tq_en_i) begin
            prev_q <= bus_i;
        end
    end

    assign fall_o = tq_en_i & prev_q & ~bus_i;

endmodule

// File: rtl/cbt_cfg_clamp.sv
module cbt_cfg_clamp
    import cbt_pkg::*;
#(
    parameter int unsigned SEG_W = 4,
    parameter int unsigned CNT_W = SEG_W + 2
) (
    input  logic [SEG_W-1:0] prop_i,
    input  logic [SEG_W-1:0] ph1_i,
    input  logic [SEG_W-1:0] ph2_i,
    input  logic [SEG_W-1:0] sjw_i,
    output logic [CNT_W-1:0] prop_o,
    output logic [CNT_W-1:0] ph1_o,
    output logic [CNT_W-1:0] ph2_o,
    output logic [CNT_W-1:0] sjw_o
);

    localparam logic [CNT_W-1:0] ONE_L = CNT_W'(1);
    localparam logic [CNT_W-1:0] IPT_L = CNT_W'(IPT_TQ);

    logic [CNT_W-1:0] ph2_wide;
    logic [CNT_W-1:0] sjw_wide;
    logic [CNT_W-1:0] ph2_fix;

    always_comb begin
        ph2_wide = CNT_W'(ph2_i);
        sjw_wide = CNT_W'(sjw_i);
        prop_o   = (prop_i == '0) ? ONE_L : CNT_W'(prop_i);
        ph1_o    = (ph1_i == '0) ? ONE_L : CNT_W'(ph1_i);
        ph2_fix  = (ph2_wide < IPT_L) ? IPT_L : ph2_wide;
        ph2_o    = ph2_fix;
        sjw_o    = (sjw_wide > ph2_fix) ? ph2_fix : sjw_wide;
    end

endmodule

// File: rtl/cbt_seg_seq.sv
module cbt_seg_seq
    import cbt_pkg::*;
#(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tq_en_i,
    input  logic             fall_i,
    input  logic             idle_i,
    input  logic [CNT_W-1:0] prop_len_i,
    input  logic [CNT_W-1:0] ph1_len_i,
    input  logic [CNT_W-1:0] ph2_len_i,
    input  logic [CNT_W-1:0] sjw_i,
    output logic             sample_o,
    output logic             bound_o,
    output seg_e             seg_o
);

    localparam logic [CNT_W-1:0] ONE_L = CNT_W'(1);
    localparam logic [CNT_W-1:0] IPT_L = CNT_W'(IPT_TQ);

    // Registered position inside the bit
    seg_e             seg_q, seg_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W-1:0] ext_q, ext_n;     // stretch applied to phase segment 1
    logic [CNT_W-1:0] lim_q, lim_n;     // effective phase segment 2 length
    logic             synced_q, synced_n;

    // Free-running advance, before any synchronization
    seg_e             nseg;
    logic [CNT_W-1:0] ncnt;
    logic [CNT_W-1:0] seg_len;
    logic             last;

    // Phase error evaluation
    logic [CNT_W-1:0] err;
    logic [CNT_W-1:0] corr;
    logic [CNT_W-1:0] lim_short;
    logic [CNT_W-1:0] lim_new;
    logic             resync_ok;
    sync_act_t        act;

    // Length of the segment being counted
    always_comb begin
        unique case (seg_q)
            SEG_PROP: seg_len = prop_len_i;
            SEG_PH1:  seg_len = ph1_len_i + ext_q;
            SEG_PH2:  seg_len = lim_q;
            default:  seg_len = ONE_L;
        endcase
        last = ((cnt_q + ONE_L) == seg_len);
    end

    // Position the next tick would reach with no correction
    always_comb begin
        nseg = seg_q;
        ncnt = cnt_q + ONE_L;
        if (seg_q == SEG_IDLE) begin
            ncnt = '0;
        end else if (last) begin
            ncnt = '0;
            unique case (seg_q)
                SEG_SYNC: nseg = SEG_PROP;
                SEG_PROP: nseg = SEG_PH1;
                SEG_PH1:  nseg = SEG_PH2;
                SEG_PH2:  nseg = SEG_SYNC;
                default:  nseg = SEG_IDLE;
            endcase
        end
    end

    // Classify the edge, size the correction
    always_comb begin
        resync_ok = tq_en_i & fall_i & ~idle_i & ~synced_q & (seg_q != SEG_IDLE);

        act.hard  = tq_en_i & fall_i & idle_i & ~synced_q;
        act.late  = resync_ok & ((nseg == SEG_PROP) | (nseg == SEG_PH1));
        act.early = resync_ok & (nseg == SEG_PH2);

        unique case (nseg)
            SEG_PROP: err = ncnt + ONE_L;
            SEG_PH1:  err = prop_len_i + ncnt + ONE_L;
            SEG_PH2:  err = lim_q - ncnt;
            default:  err = '0;
        endcase

        corr        = (err > sjw_i) ? sjw_i : err;
        lim_short   = lim_q - corr;
        lim_new     = (lim_short < IPT_L) ? IPT_L : lim_short;
        act.end_now = act.early & (lim_new == ncnt);
    end

    // Strobes, gated by the tick and masked on a hard restart
    assign sample_o = tq_en_i & ~act.hard & (seg_q == SEG_PH1) & last;
    assign bound_o  = tq_en_i & ~act.hard &
                      (((seg_q == SEG_PH2) & last) | act.end_now);
    assign seg_o    = seg_q;

    // State update
    always_comb begin
        seg_n    = seg_q;
        cnt_n    = cnt_q;
        ext_n    = ext_q;
        lim_n    = lim_q;
        synced_n = synced_q;
        if (tq_en_i) begin
            if (act.hard) begin
                seg_n    = SEG_SYNC;
                cnt_n    = '0;
                ext_n    = '0;
                lim_n    = ph2_len_i;
                synced_n = 1'b1;
            end else if (act.end_now || ((seg_q != SEG_IDLE) && (nseg == SEG_SYNC))) begin
                seg_n    = SEG_SYNC;
                cnt_n    = '0;
                ext_n    = '0;
                lim_n    = ph2_len_i;
                synced_n = 1'b0;
            end else begin
                seg_n = nseg;
                cnt_n = ncnt;
                if (act.late) begin
                    ext_n    = corr;
                    synced_n = 1'b1;
                end
                if (act.early) begin
                    lim_n    = lim_new;
                    synced_n = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            seg_q    <= SEG_IDLE;
            cnt_q    <= '0;
            ext_q    <= '0;
            lim_q    <= IPT_L;
            synced_q <= 1'b0;
        end else begin
            seg_q    <= seg_n;
            cnt_q    <= cnt_n;
            ext_q    <= ext_n;
            lim_q    <= lim_n;
            synced_q <= synced_n;
        end
    end

endmodule

// File: rtl/cbt_bit_timer.sv
module cbt_bit_timer
    import cbt_pkg::*;
#(
    parameter int unsigned SEG_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tq_en_i,
    input  logic             bus_i,
    input  logic             bus_idle_i,
    input  logic [SEG_W-1:0] prop_seg_i,
    input  logic [SEG_W-1:0] ph1_seg_i,
    input  logic [SEG_W-1:0] ph2_seg_i,
    input  logic [SEG_W-1:0] sjw_i,
    output logic             sample_o,
    output logic             bit_o,
    output logic             bound_o
);

    // Room for a stretched phase segment and the phase error sum
    localparam int unsigned CNT_W = SEG_W + 2;

    logic             fall;
    logic [CNT_W-1:0] prop_len, ph1_len, ph2_len, sjw_len;
    logic             sample_s;
    logic             bit_q;
    seg_e             seg_now;

    cbt_edge_det u_edge (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tq_en_i (tq_en_i),
        .bus_i   (bus_i),
        .fall_o  (fall)
    );

    cbt_cfg_clamp #(
        .SEG_W (SEG_W),
        .CNT_W (CNT_W)
    ) u_clamp (
        .prop_i (prop_seg_i),
        .ph1_i  (ph1_seg_i),
        .ph2_i  (ph2_seg_i),
        .sjw_i  (sjw_i),
        .prop_o (prop_len),
        .ph1_o  (ph1_len),
        .ph2_o  (ph2_len),
        .sjw_o  (sjw_len)
    );

    cbt_seg_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .tq_en_i    (tq_en_i),
        .fall_i     (fall),
        .idle_i     (bus_idle_i),
        .prop_len_i (prop_len),
        .ph1_len_i  (ph1_len),
        .ph2_len_i  (ph2_len),
        .sjw_i      (sjw_len),
        .sample_o   (sample_s),
        .bound_o    (bound_o),
        .seg_o      (seg_now)
    );

    // Captured bit, recessive out of reset
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            bit_q <= 1'b1;
        end else if (sample_s) begin
            bit_q <= bus_i;
        end
    end

    assign sample_o = sample_s;
    assign bit_o    = bit_q;

endmodule

// File: rtl/cbt_bit_timer_chk.sv
module cbt_bit_timer_chk
    import cbt_pkg::*;
(
    input logic clk_i,
    input logic rst_i,
    input logic tq_en_i,
    input logic bus_i,
    input logic sample_o,
    input logic bit_o,
    input logic bound_o,
    input seg_e seg_now
);

    // Ticks since the last sample strobe
    logic [7:0] gap_q;
    logic       seen_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (sample_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (tq_en_i && (gap_q != 8'hFF)) begin
            gap_q <= gap_q + 8'd1;
        end
    end

    AST_SAMPLE_ON_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
        sample_o |-> tq_en_i); // R4

    AST_BOUND_ON_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
        bound_o |-> tq_en_i); // R4

    AST_BIT_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
        sample_o |=> (bit_o == $past(bus_i))); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (seg_now == SEG_IDLE) |-> !(sample_o || bound_o)); // R1

    AST_STROBES_APART: assert property (@(posedge clk_i) disable iff (rst_i)
        !(sample_o && bound_o)); // R11

    AST_IPT_FLOOR: assert property (@(posedge clk_i) disable iff (rst_i)
        (bound_o && seen_q) |-> (gap_q >= 8'(IPT_TQ - 1))); // R11

endmodule

bind cbt_bit_timer cbt_bit_timer_chk u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .tq_en_i  (tq_en_i),
    .bus_i    (bus_i),
    .sample_o (sample_o),
    .bit_o    (bit_o),
    .bound_o  (bound_o),
    .seg_now  (seg_now)
);

// File: tb/sim_cbt_bit_timer.sv
`timescale 1ns/1ps
module sim_cbt_bit_timer;

    localparam int SEG_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tq_en = 1'b0;
    logic             bus = 1'b1;
    logic             idle = 1'b0;
    logic [SEG_W-1:0] prop = '0, ph1 = '0, ph2 = '0, sjw = '0;
    logic             sample, bitv, bound;

    cbt_bit_timer #(.SEG_W(SEG_W)) u0 (
        .clk_i      (clk),
        .rst_i      (rst),
        .tq_en_i    (tq_en),
        .bus_i      (bus),
        .bus_idle_i (idle),
        .prop_seg_i (prop),
        .ph1_seg_i  (ph1),
        .ph2_seg_i  (ph2),
        .sjw_i      (sjw),
        .sample_o   (sample),
        .bit_o      (bitv),
        .bound_o    (bound)
    );

    always #2 clk = ~clk;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   tick_no, ns, nb, leaks = 0;
    int   smp [16];
    int   bnd [16];
    logic bitlog [64];
    bit   done = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One quantum tick: bus and idle set, strobes logged by tick number
    task automatic step(input logic b, input logic id);
        @(negedge clk);
        bus = b; idle = id; tq_en = 1'b1;
        #1;
        if (sample) begin if (ns < 16) smp[ns] = tick_no; ns++; end
        if (bound)  begin if (nb < 16) bnd[nb] = tick_no; nb++; end
        @(negedge clk);
        tq_en = 1'b0;
        #1;
        if (sample || bound) leaks++;
        if (tick_no >= 0 && tick_no < 64) bitlog[tick_no] = bitv;
        @(negedge clk);
        @(negedge clk);
        tick_no++;
    endtask

    task automatic start(input int p, input int a, input int b, input int j);
        @(negedge clk);
        prop = SEG_W'(p); ph1 = SEG_W'(a); ph2 = SEG_W'(b); sjw = SEG_W'(j);
        rst = 1'b1; tq_en = 1'b0; bus = 1'b1; idle = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ns = 0; nb = 0; tick_no = -2;
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
    endtask

    task automatic expect_seq(input string req, input int n,
                              input int s0, input int s1, input int s2,
                              input int b0, input int b1, input int b2);
        check({req, " sample count"}, ns, n);
        check({req, " boundary count"}, nb, n);
        if (n > 0) begin check({req, " sample0"}, smp[0], s0); check({req, " bound0"}, bnd[0], b0); end
        if (n > 1) begin check({req, " sample1"}, smp[1], s1); check({req, " bound1"}, bnd[1], b1); end
        if (n > 2) begin check({req, " sample2"}, smp[2], s2); check({req, " bound2"}, bnd[2], b2); end
    endtask

    task automatic t_reset;
        start(2, 3, 3, 2);
        check("R1 bit_o after reset", int'(bitv), 1);
        for (int t = 0; t < 12; t++) step(1'b1, 1'b0);
        expect_seq("R1 idle", 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_nominal;
        start(2, 3, 3, 2);
        for (int t = 0; t < 20; t++) step((t <= 6) ? 1'b0 : 1'b1, t == 0);
        expect_seq("R3 nominal", 2, 6, 15, 0, 9, 18, 0);
        check("R4 bit at first sample", int'(bitlog[6]), 0);
        check("R4 bit at second sample", int'(bitlog[15]), 1);
    endtask

    task automatic t_idle_gate;
        start(2, 3, 3, 2);
        for (int t = 0; t < 16; t++) step((t <= 2 || t >= 6) ? 1'b0 : 1'b1, t == 6);
        expect_seq("R2 idle gate", 1, 12, 0, 0, 15, 0, 0);
    endtask

    task automatic t_late(input int d, input int s1, input int b1);
        start(2, 3, 3, 2);
        for (int t = 0; t < 22; t++)
            step((t <= 2) ? 1'b0 : ((t < 9 + d) ? 1'b1 : 1'b0), t == 0);
        expect_seq("R5 late edge", 2, 6, s1, 0, 9, b1, 0);
    endtask

    task automatic t_early(input string req, input int e_tick);
        start(2, 3, 3, 2);
        for (int t = 0; t < 27; t++)
            step((t <= 2) ? 1'b0 : ((t < e_tick) ? 1'b1 : 1'b0), t == 0);
        expect_seq(req, 3, 6, 15, 23, 9, 17, 26);
    endtask

    task automatic t_sjw_cap;
        start(1, 2, 5, 2);
        for (int t = 0; t < 26; t++)
            step((t <= 2) ? 1'b0 : ((t < 15) ? 1'b1 : 1'b0), t == 0);
        expect_seq("R6 capped trim", 3, 4, 13, 20, 9, 16, 25);
    endtask

    task automatic t_on_sync;
        start(2, 3, 3, 2);
        for (int t = 0; t < 19; t++)
            step((t <= 2) ? 1'b0 : ((t < 9) ? 1'b1 : 1'b0), t == 0);
        expect_seq("R7 edge on sync", 2, 6, 15, 0, 9, 18, 0);
    endtask

    task automatic t_double;
        start(2, 3, 3, 2);
        for (int t = 0; t < 20; t++)
            step((t <= 2) ? 1'b0 : (t <= 9) ? 1'b1 : (t == 10) ? 1'b0 : (t == 11) ? 1'b1 : 1'b0,
                 t == 0);
        expect_seq("R8 second edge", 2, 6, 16, 0, 9, 19, 0);
    endtask

    task automatic t_clamp;
        start(0, 4, 0, 7);
        for (int t = 0; t < 19; t++)
            step((t <= 2) ? 1'b0 : ((t < 12) ? 1'b1 : 1'b0), t == 0);
        expect_seq("R9 clamp", 2, 6, 16, 0, 8, 18, 0);
    endtask

    task automatic t_rehard;
        start(2, 3, 3, 2);
        for (int t = 0; t < 22; t++)
            step((t <= 2) ? 1'b0 : ((t < 12) ? 1'b1 : 1'b0), 1'b1);
        expect_seq("R10 hard restart", 2, 6, 18, 0, 9, 21, 0);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        t_reset();
        t_nominal();
        t_idle_gate();
        t_late(1, 16, 19);
        t_late(4, 17, 20);
        t_early("R6 full trim", 17);
        t_early("R11 processing floor", 16);
        t_sjw_cap();
        t_on_sync();
        t_double();
        t_clamp();
        t_rehard();
        check("R4 strobe width", leaks, 0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule